// File: doc/BRIEF.md
# LPC I/O Cycle Target

This block sits on the peripheral side of a Low Pin Count bus and answers host I/O read and I/O write cycles. It watches the frame strobe and the four-bit multiplexed bus and picks up the start and cycle-type nibbles. It collects a 16-bit I/O address and claims the cycle only when that address lies inside a parameterised window. Each claimed cycle becomes exactly one single-byte access on a simple local port, which carries an address, write data, read data, one-clock read and write strobes, a ready handshake and an error flag.

Every claimed cycle returns at least one wait-state sync nibble before the final sync. While the local side holds its ready input low, the block reports a long wait. When ready arrives it reports completion or, if the local error flag is set, an error code. It handles both bus turnarounds itself. A new frame strobe in the middle of a cycle aborts that cycle at once. Cycles outside the window, or of any other type, leave the bus untouched.

Top module: `lpc_io_target`

## Requirements
- R1: On the clock after the start nibble (frame low, bus 0000), frame high with a type nibble of 000x marks an I/O read and 001x an I/O write. Any other type nibble sends the block back to idle. In that case it never drives the bus and issues no strobe.
- R2: The four address nibbles follow the type nibble, most significant first. The cycle is claimed only if the address satisfies WIN_BASE <= addr < WIN_BASE + WIN_SIZE. An unclaimed cycle produces no bus drive and no strobe, and `loc_addr` holds the claimed address during the strobe.
- R3: The first nibble the target drives in every claimed cycle is the short-wait sync 0101. It appears on the clock after the second host turnaround clock, so a cycle never completes with zero wait states.
- R4: At each clock of the sync phase, `loc_ready` is sampled. While it is low, the next nibble is the long-wait sync 0110. Once it is high, the next nibble is the final sync 0000.
- R5: If `loc_err` is high on the clock where `loc_ready` is sampled high, the final sync is the error code 1010 instead of 0000.
- R6: For a write, the two data nibbles arrive low nibble first, before the two turnaround clocks. `loc_wr_stb` is high for exactly one clock, which is the clock of the first sync nibble, and `loc_wdata` carries the assembled byte.
- R7: For a read, `loc_rd_stb` is high for exactly one clock, which is the clock of the first sync nibble. After the final sync, the byte on `loc_rdata` captured with ready is driven low nibble first, then high nibble.
- R8: After its last sync (write) or data nibble (read), the target drives 1111 for one clock and then releases the bus.
- R9: If frame goes low at any point after the type nibble, the cycle is abandoned. The bus is released on the next clock, and no strobe is issued if the sync phase has not yet begun. A 0000 nibble on that same clock is taken as a new start.
- R10: While `lreset_n` is low, the frame input is ignored, the bus is never driven and no strobe is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lclk | input | 1 | Bus clock |
| lreset_n | input | 1 | Active-low asynchronous reset |
| lframe_n | input | 1 | Active-low frame strobe from the host |
| lad_in | input | 4 | Multiplexed bus value as seen at the pins |
| lad_out | output | 4 | Nibble the target drives |
| lad_oe | output | 1 | Output enable for `lad_out` |
| loc_addr | output | 16 | I/O address of the claimed cycle |
| loc_wdata | output | 8 | Write byte for the local port |
| loc_rdata | input | 8 | Read byte from the local port, captured with ready |
| loc_rd_stb | output | 1 | One-clock read request |
| loc_wr_stb | output | 1 | One-clock write request |
| loc_ready | input | 1 | Local access complete |
| loc_err | input | 1 | Local access failed, valid with ready |

## Verification
Take the posedge that samples the second host turnaround nibble as edge T. The short-wait nibble and the single strobe are visible in the clock after T. Each later sync nibble reflects `loc_ready` and `loc_err` as sampled on the preceding edge. Read data nibbles, the 1111 hand-back and the release then follow one clock apart. Abort release and type or window rejection take effect one clock after the sampling edge. The bench drives every host nibble just after a falling edge and reads every output at the next falling edge, so each check sees the state one rising edge after its stimulus. It sweeps addresses across both window edges, both directions, both type-nibble variants, zero to two wait clocks and both error outcomes, and computes each expected nibble from those inputs.

// File: rtl/lpc_io_pkg.sv
package lpc_io_pkg;

    localparam int unsigned IO_ADDR_W  = 16;
    localparam int unsigned IO_DATA_W  = 8;
    localparam int unsigned NIB_W      = 4;
    localparam int unsigned ADDR_NIBS  = IO_ADDR_W / NIB_W;

    localparam logic [NIB_W-1:0] NIB_START   = 4'b0000;
    localparam logic [NIB_W-1:0] NIB_RELEASE = 4'b1111;
    localparam logic [NIB_W-1:0] SYNC_DONE   = 4'b0000;
    localparam logic [NIB_W-1:0] SYNC_SHORT  = 4'b0101;
    localparam logic [NIB_W-1:0] SYNC_LONG   = 4'b0110;
    localparam logic [NIB_W-1:0] SYNC_FAIL   = 4'b1010;

    typedef enum logic [3:0] {
        S_IDLE    = 4'd0,
        S_START   = 4'd1,
        S_ADDR    = 4'd2,
        S_WDATA   = 4'd3,
        S_TAR_IN  = 4'd4,
        S_SYNC    = 4'd5,
        S_FINAL   = 4'd6,
        S_RDATA   = 4'd7,
        S_TAR_OUT = 4'd8
    } lpc_state_e;

    typedef enum logic [1:0] {
        CYC_NONE  = 2'd0,
        CYC_IO_RD = 2'd1,
        CYC_IO_WR = 2'd2
    } cyc_kind_e;

    typedef struct packed {
        lpc_state_e             state;
        logic                   is_wr;
        logic [1:0]             cnt;
        logic [IO_ADDR_W-1:0]   addr;
        logic [IO_DATA_W-1:0]   wdata;
        logic [IO_DATA_W-1:0]   rdata;
        logic                   err;
        logic                   first;
    } lpc_regs_t;

endpackage

// File: rtl/lpc_cycle_decode.sv
module lpc_cycle_decode
    import lpc_io_pkg::*;
(
    input  logic [2:0] type_hi,
    output cyc_kind_e  kind
);
    always_comb begin
        unique case (type_hi)
            3'b000:  kind = CYC_IO_RD;
            3'b001:  kind = CYC_IO_WR;
            default: kind = CYC_NONE;
        endcase
    end
endmodule

// File: rtl/lpc_addr_window.sv
module lpc_addr_window #(
    parameter int unsigned W    = 16,
    parameter int unsigned BASE = 16'h03F8,
    parameter int unsigned SIZE = 8
) (
    input  logic [W-1:0] addr,
    output logic         hit
);
    localparam bit ALIGNED_POW2 = ((SIZE & (SIZE - 1)) == 0) && ((BASE % SIZE) == 0);

    generate
        if (ALIGNED_POW2) begin : g_mask
            localparam logic [W-1:0] MASK = ~W'(SIZE - 1);
            localparam logic [W-1:0] BVAL = W'(BASE);
            assign hit = (addr & MASK) == BVAL;
        end else begin : g_range
            localparam logic [W:0] LO = (W + 1)'(BASE);
            localparam logic [W:0] HI = (W + 1)'(BASE + SIZE);
            assign hit = ({1'b0, addr} >= LO) && ({1'b0, addr} < HI);
        end
    endgenerate
endmodule

// File: rtl/lpc_lad_driver.sv
module lpc_lad_driver
    import lpc_io_pkg::*;
(
    input  lpc_state_e             state,
    input  logic                   first,
    input  logic                   err,
    input  logic                   hi_nib,
    input  logic [IO_DATA_W-1:0]   rdata,
    output logic [NIB_W-1:0]       lad_out,
    output logic                   lad_oe
);
    always_comb begin
        lad_oe  = 1'b1;
        lad_out = NIB_RELEASE;
        case (state)
            S_SYNC:    lad_out = first ? SYNC_SHORT : SYNC_LONG;
            S_FINAL:   lad_out = err ? SYNC_FAIL : SYNC_DONE;
            S_RDATA:   lad_out = hi_nib ? rdata[7:4] : rdata[3:0];
            S_TAR_OUT: lad_out = NIB_RELEASE;
            default: begin
                lad_oe  = 1'b0;
                lad_out = NIB_RELEASE;
            end
        endcase
    end
endmodule

// File: rtl/lpc_io_target.sv
module lpc_io_target
    import lpc_io_pkg::*;
#(
    parameter int unsigned WIN_BASE = 16'h03F8,
    parameter int unsigned WIN_SIZE = 8
) (
    input  logic        lclk,
    input  logic        lreset_n,
    input  logic        lframe_n,
    input  logic [3:0]  lad_in,
    output logic [3:0]  lad_out,
    output logic        lad_oe,
    output logic [15:0] loc_addr,
    output logic [7:0]  loc_wdata,
    input  logic [7:0]  loc_rdata,
    output logic        loc_rd_stb,
    output logic        loc_wr_stb,
    input  logic        loc_ready,
    input  logic        loc_err
);
    localparam logic [1:0] LAST_ADDR = 2'(ADDR_NIBS - 1);

    lpc_regs_t q, d;

    cyc_kind_e            kind;
    logic                 addr_hit;
    logic [IO_ADDR_W-1:0] addr_next;
    logic                 start_seen;

    assign addr_next  = {q.addr[IO_ADDR_W-NIB_W-1:0], lad_in};
    assign start_seen = !lframe_n && (lad_in == NIB_START);

    lpc_cycle_decode u_decode (
        .type_hi (lad_in[3:1]),
        .kind    (kind)
    );

    lpc_addr_window #(
        .W    (IO_ADDR_W),
        .BASE (WIN_BASE),
        .SIZE (WIN_SIZE)
    ) u_window (
        .addr (addr_next),
        .hit  (addr_hit)
    );

    always_comb begin
        d       = q;
        d.first = 1'b0;
        case (q.state)
            S_IDLE: begin
                if (start_seen) d.state = S_START;
            end
            S_START: begin
                if (!lframe_n) begin
                    d.state = start_seen ? S_START : S_IDLE;
                end else begin
                    d.cnt = 2'd0;
                    case (kind)
                        CYC_IO_RD: begin d.state = S_ADDR; d.is_wr = 1'b0; end
                        CYC_IO_WR: begin d.state = S_ADDR; d.is_wr = 1'b1; end
                        default:   d.state = S_IDLE;
                    endcase
                end
            end
            S_ADDR: begin
                d.addr = addr_next;
                d.cnt  = q.cnt + 2'd1;
                if (q.cnt == LAST_ADDR) begin
                    d.cnt = 2'd0;
                    if (!addr_hit)   d.state = S_IDLE;
                    else if (q.is_wr) d.state = S_WDATA;
                    else             d.state = S_TAR_IN;
                end
            end
            S_WDATA: begin
                if (q.cnt == 2'd0) begin
                    d.wdata[3:0] = lad_in;
                    d.cnt        = 2'd1;
                end else begin
                    d.wdata[7:4] = lad_in;
                    d.cnt        = 2'd0;
                    d.state      = S_TAR_IN;
                end
            end
            S_TAR_IN: begin
                if (q.cnt == 2'd0) begin
                    d.cnt = 2'd1;
                end else begin
                    d.cnt   = 2'd0;
                    d.state = S_SYNC;
                    d.first = 1'b1;
                end
            end
            S_SYNC: begin
                if (loc_ready) begin
                    d.state = S_FINAL;
                    d.err   = loc_err;
                    d.rdata = loc_rdata;
                end
            end
            S_FINAL: begin
                d.cnt   = 2'd0;
                d.state = q.is_wr ? S_TAR_OUT : S_RDATA;
            end
            S_RDATA: begin
                if (q.cnt == 2'd0) d.cnt = 2'd1;
                else               d.state = S_TAR_OUT;
            end
            S_TAR_OUT: d.state = S_IDLE;
            default:   d.state = S_IDLE;
        endcase

        // a fresh frame strobe during any claimed phase abandons the cycle
        if (!lframe_n && (q.state != S_IDLE) && (q.state != S_START)) begin
            d.state = start_seen ? S_START : S_IDLE;
            d.first = 1'b0;
            d.cnt   = 2'd0;
        end
    end

    always_ff @(posedge lclk or negedge lreset_n) begin
        if (!lreset_n) q <= '0;
        else           q <= d;
    end

    lpc_lad_driver u_drv (
        .state   (q.state),
        .first   (q.first),
        .err     (q.err),
        .hi_nib  (q.cnt[0]),
        .rdata   (q.rdata),
        .lad_out (lad_out),
        .lad_oe  (lad_oe)
    );

    assign loc_addr   = q.addr;
    assign loc_wdata  = q.wdata;
    assign loc_rd_stb = (q.state == S_SYNC) && q.first && !q.is_wr;
    assign loc_wr_stb = (q.state == S_SYNC) && q.first && q.is_wr;

endmodule

// File: rtl/lpc_io_target_chk.sv
module lpc_io_target_chk #(
    parameter int unsigned WIN_BASE = 16'h03F8,
    parameter int unsigned WIN_SIZE = 8
) (
    input logic        lclk,
    input logic        lreset_n,
    input logic        lframe_n,
    input logic [3:0]  lad_out,
    input logic        lad_oe,
    input logic [15:0] loc_addr,
    input logic        loc_rd_stb,
    input logic        loc_wr_stb,
    input logic        loc_ready
);
    localparam logic [16:0] LO = 17'(WIN_BASE);
    localparam logic [16:0] HI = 17'(WIN_BASE + WIN_SIZE);

    always @(posedge lclk) begin
        if (!lreset_n) begin
            a_r10_quiet_in_reset: assert (!lad_oe && !loc_rd_stb && !loc_wr_stb);
        end
    end

    a_r2_strobe_in_window: assert property (@(posedge lclk) disable iff (!lreset_n)
        (loc_rd_stb || loc_wr_stb) |-> (({1'b0, loc_addr} >= LO) && ({1'b0, loc_addr} < HI)));

    a_r3_first_drive_short: assert property (@(posedge lclk) disable iff (!lreset_n)
        $rose(lad_oe) |-> (lad_out == 4'b0101));

    a_r4_long_only_unready: assert property (@(posedge lclk) disable iff (!lreset_n)
        (lad_oe && lad_out == 4'b0110) |-> !$past(loc_ready));

    a_r6_wr_pulse: assert property (@(posedge lclk) disable iff (!lreset_n)
        loc_wr_stb |=> !loc_wr_stb);

    a_r7_rd_pulse: assert property (@(posedge lclk) disable iff (!lreset_n)
        loc_rd_stb |=> !loc_rd_stb);

    a_r7_rd_with_short: assert property (@(posedge lclk) disable iff (!lreset_n)
        loc_rd_stb |-> (lad_oe && lad_out == 4'b0101));

    a_r8_release_after_ones: assert property (@(posedge lclk) disable iff (!lreset_n)
        ($fell(lad_oe) && $past(lframe_n)) |-> ($past(lad_out) == 4'b1111));

    a_r9_abort_release: assert property (@(posedge lclk) disable iff (!lreset_n)
        (lad_oe && !lframe_n) |=> !lad_oe);

endmodule

bind lpc_io_target lpc_io_target_chk #(
    .WIN_BASE (WIN_BASE),
    .WIN_SIZE (WIN_SIZE)
) u_chk (
    .lclk       (lclk),
    .lreset_n   (lreset_n),
    .lframe_n   (lframe_n),
    .lad_out    (lad_out),
    .lad_oe     (lad_oe),
    .loc_addr   (loc_addr),
    .loc_rd_stb (loc_rd_stb),
    .loc_wr_stb (loc_wr_stb),
    .loc_ready  (loc_ready)
);

// File: tb/lpc_io_target_test.sv
`timescale 1ns/1ps
module lpc_io_target_test;
    localparam int BASE = 16'h03F8;
    localparam int SIZE = 8;

    logic        lclk = 1'b0;
    logic        lreset_n = 1'b0;
    logic        lframe_n = 1'b1;
    logic [3:0]  lad_in = 4'hF;
    logic [3:0]  lad_out;
    logic        lad_oe;
    logic [15:0] loc_addr;
    logic [7:0]  loc_wdata;
    logic [7:0]  loc_rdata = 8'h00;
    logic        loc_rd_stb;
    logic        loc_wr_stb;
    logic        loc_ready = 1'b0;
    logic        loc_err = 1'b0;

    int errors = 0;
    int checks = 0;
    int stb_cnt = 0;

    always #10 lclk = ~lclk;

    lpc_io_target #(.WIN_BASE(BASE), .WIN_SIZE(SIZE)) uut (
        .lclk(lclk), .lreset_n(lreset_n), .lframe_n(lframe_n), .lad_in(lad_in),
        .lad_out(lad_out), .lad_oe(lad_oe), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
        .loc_rdata(loc_rdata), .loc_rd_stb(loc_rd_stb), .loc_wr_stb(loc_wr_stb),
        .loc_ready(loc_ready), .loc_err(loc_err)
    );

    always @(posedge lclk) if (loc_rd_stb || loc_wr_stb) stb_cnt++;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic fr, input logic [3:0] n);
        lframe_n = fr;
        lad_in   = n;
        @(posedge lclk);
        @(negedge lclk);
    endtask

    task automatic head(input bit wr, input bit tl, input logic [15:0] a);
        step(1'b0, 4'h0);
        step(1'b1, {2'b00, wr, tl});
        for (int i = 3; i >= 0; i--) step(1'b1, a[4*i +: 4]);
    endtask

    task automatic xfer(input bit wr, input logic [15:0] a, input bit tl, input int waits,
                        input bit err, input logic [7:0] wd, input logic [7:0] rd);
        int  s0;
        bit  hit;
        s0  = stb_cnt;
        hit = (int'(a) >= BASE) && (int'(a) < BASE + SIZE);
        head(wr, tl, a);
        if (!hit) begin
            for (int i = 0; i < 8; i++) step(1'b1, 4'hF);
            chk("R2 miss no drive", {15'd0, lad_oe}, 16'd0);
            chk("R2 miss no strobe", 16'(stb_cnt - s0), 16'd0);
            return;
        end
        if (wr) begin
            step(1'b1, wd[3:0]);
            step(1'b1, wd[7:4]);
        end
        step(1'b1, 4'hF);
        loc_ready = 1'b0;
        step(1'b1, 4'hF);
        chk("R3 first sync short", {11'd0, lad_oe, lad_out}, 16'h0015);
        chk(wr ? "R6 write strobe" : "R7 read strobe", {14'd0, loc_wr_stb, loc_rd_stb},
            wr ? 16'd2 : 16'd1);
        chk("R2 claimed address", loc_addr, a);
        if (wr) chk("R6 write byte", {8'd0, loc_wdata}, {8'd0, wd});
        for (int w = 0; w < waits; w++) begin
            step(1'b1, 4'hF);
            chk("R4 long wait", {11'd0, lad_oe, lad_out}, 16'h0016);
        end
        loc_ready = 1'b1;
        loc_err   = err;
        loc_rdata = rd;
        step(1'b1, 4'hF);
        loc_ready = 1'b0;
        loc_err   = 1'b0;
        loc_rdata = 8'h00;
        chk(err ? "R5 error sync" : "R4 ready sync", {11'd0, lad_oe, lad_out},
            err ? 16'h001A : 16'h0010);
        if (!wr) begin
            step(1'b1, 4'hF);
            chk("R7 read low nibble", {11'd0, lad_oe, lad_out}, {11'd0, 1'b1, rd[3:0]});
            step(1'b1, 4'hF);
            chk("R7 read high nibble", {11'd0, lad_oe, lad_out}, {11'd0, 1'b1, rd[7:4]});
        end
        step(1'b1, 4'hF);
        chk("R8 hand back ones", {11'd0, lad_oe, lad_out}, 16'h001F);
        step(1'b1, 4'hF);
        chk("R8 released", {15'd0, lad_oe}, 16'd0);
        chk(wr ? "R6 single strobe" : "R7 single strobe", 16'(stb_cnt - s0), 16'd1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge lclk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin : main
        int s0;
        repeat (3) @(negedge lclk);
        // R10: frame and start ignored while reset is held
        step(1'b0, 4'h0);
        step(1'b1, 4'h0);
        for (int i = 0; i < 10; i++) step(1'b1, 4'h3);
        chk("R10 no drive in reset", {13'd0, lad_oe, loc_rd_stb, loc_wr_stb}, 16'd0);
        chk("R10 no strobe in reset", 16'(stb_cnt), 16'd0);
        lreset_n = 1'b1;
        step(1'b1, 4'hF);
        chk("R10 reset state", {13'd0, lad_oe, loc_rd_stb, loc_wr_stb}, 16'd0);

        // sweep over window edges, direction, type lsb, waits and error
        for (int a = BASE - 2; a < BASE + SIZE + 2; a++)
            for (int wr = 0; wr < 2; wr++)
                for (int w = 0; w < 3; w++)
                    for (int e = 0; e < 2; e++)
                        xfer(wr[0], 16'(a), w[0], w, e[0],
                             8'((a * 7 + w * 29 + e) & 255), 8'(~a ^ (w * 19 + e * 90)));

        // R1: non-I/O types are not claimed
        for (int t = 4; t < 16; t++) begin
            s0 = stb_cnt;
            step(1'b0, 4'h0);
            step(1'b1, 4'(t));
            step(1'b1, 4'h0); step(1'b1, 4'h3); step(1'b1, 4'hF); step(1'b1, 4'h8);
            for (int i = 0; i < 8; i++) step(1'b1, 4'hF);
            chk("R1 other type ignored", {15'd0, lad_oe}, 16'd0);
            chk("R1 other type no strobe", 16'(stb_cnt - s0), 16'd0);
        end

        // R9: abort in address phase, then a restart on the abort clock
        s0 = stb_cnt;
        step(1'b0, 4'h0); step(1'b1, 4'h2); step(1'b1, 4'h0); step(1'b1, 4'h3);
        step(1'b0, 4'hF);
        chk("R9 abort addr no drive", {15'd0, lad_oe}, 16'd0);
        step(1'b1, 4'hF);
        chk("R9 abort addr no strobe", 16'(stb_cnt - s0), 16'd0);
        step(1'b0, 4'h0); step(1'b1, 4'h2); step(1'b1, 4'h0); step(1'b1, 4'h3);
        xfer(1'b1, 16'h03FA, 1'b0, 1, 1'b0, 8'hC3, 8'h00);

        // R9: abort while waiting in the sync phase
        head(1'b0, 1'b0, 16'h03F9);
        step(1'b1, 4'hF);
        loc_ready = 1'b0;
        step(1'b1, 4'hF);
        step(1'b1, 4'hF);
        chk("R9 sync driving before abort", {11'd0, lad_oe, lad_out}, 16'h0016);
        step(1'b0, 4'hF);
        chk("R9 abort sync release", {15'd0, lad_oe}, 16'd0);
        step(1'b1, 4'hF);
        chk("R9 stays released", {15'd0, lad_oe}, 16'd0);
        xfer(1'b0, 16'h03FF, 1'b1, 0, 1'b0, 8'h00, 8'hF0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule